// File: doc/BRIEF.md
# Event-Divided Interrupt Flag Generator

This block sits beside a PWM timebase and turns its event strobes into a software interrupt. It counts occurrences of one chosen strobe: counter at zero, counter at period, or one of the compare matches in a given count direction. When the number of occurrences reaches a programmed divide value, it raises a sticky interrupt flag and emits a one-cycle pulse. The flag stays high until software clears it. While the flag is pending, no new interrupt is issued. The counter also stops at the divide value, so the first qualifying event after a clear fires at once.

Software selects the source with a 3-bit field, enables generation with one bit and sets the divide value with a 2-bit field. It acknowledges the interrupt by pulsing a clear input for one cycle. All outputs are registered. Each output reflects the strobe sampled at the preceding clock edge.

Top module: `evt_int_prescaler`

## Requirements
- R1: While `rst` is high, and after the edge at which it is sampled high, `irq_flag` and `irq_pulse` are 0 and the event count is zero.
- R2: `src_sel` chooses which bit of `evt_strobe` is counted. The strobe bits are [0] zero, [1] period, [2] compare A rising, [3] compare A falling, [4] compare B rising and [5] compare B falling. The `src_sel` codes are:
  - 0: nothing
  - 1: bit 0
  - 2: bit 1
  - 3: bit 0 or bit 1
  - 4: bit 2
  - 5: bit 3
  - 6: bit 4
  - 7: bit 5

  Strobes that are not selected are not counted.
- R3: `div_sel` sets the divide value: 1 fires on every selected event, 2 on every second and 3 on every third. The count starts from zero after reset or after a firing.
- R4: When `int_en` is 0 or `div_sel` is 0, no interrupt is produced and the event count is held at zero. An already pending `irq_flag` keeps its value.
- R5: `irq_flag` stays high until a cycle with `flag_clr` high. It then reads 0 after that edge, unless a firing occurs in the same cycle.
- R6: While `irq_flag` is high, selected events produce no pulse and the count saturates at the divide value. The first selected event after the clear then fires immediately.
- R7: A clear and a firing event in the same cycle leave `irq_flag` high and produce a pulse.
- R8: `irq_pulse` is high for exactly one cycle, in the cycle after the edge that sampled the firing event, and `irq_flag` rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 6 | Timebase event strobes, bit order per R2 |
| src_sel | input | 3 | Event source select code |
| int_en | input | 1 | Interrupt generation enable |
| div_sel | input | 2 | Divide value, 0 disables |
| flag_clr | input | 1 | One-cycle clear of the pending flag |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong event count shows up as a pulse one or more events early or late. The bench therefore compares the flag and the pulse after every cycle, which catches a miscount at the event where the firing should have happened. A count that wraps instead of saturating while the flag is pending delays the first post-clear interrupt, and this is visible at the first selected event after the clear. A flag that loses or keeps its state wrongly shows within one cycle of the clear, or of the disable, that should or should not have touched it.

// File: rtl/evt_int_pkg.sv
package evt_int_pkg;
  localparam int NUM_EVT = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE    = 3'd0,
    SRC_ZERO    = 3'd1,
    SRC_PERIOD  = 3'd2,
    SRC_ZOR_PRD = 3'd3,
    SRC_A_RISE  = 3'd4,
    SRC_A_FALL  = 3'd5,
    SRC_B_RISE  = 3'd6,
    SRC_B_FALL  = 3'd7
  } src_e;

  // strobe bit positions
  localparam int EV_ZERO   = 0;
  localparam int EV_PERIOD = 1;
  localparam int EV_A_RISE = 2;
  localparam int EV_A_FALL = 3;
  localparam int EV_B_RISE = 4;
  localparam int EV_B_FALL = 5;
endpackage

// File: rtl/evt_src_mux.sv
module evt_src_mux
  import evt_int_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [SEL_W-1:0]   src_sel,
  output logic               evt_hit
);
  always_comb begin
    unique case (src_e'(src_sel))
      SRC_NONE:    evt_hit = 1'b0;
      SRC_ZERO:    evt_hit = evt_strobe[EV_ZERO];
      SRC_PERIOD:  evt_hit = evt_strobe[EV_PERIOD];
      SRC_ZOR_PRD: evt_hit = evt_strobe[EV_ZERO] | evt_strobe[EV_PERIOD];
      SRC_A_RISE:  evt_hit = evt_strobe[EV_A_RISE];
      SRC_A_FALL:  evt_hit = evt_strobe[EV_A_FALL];
      SRC_B_RISE:  evt_hit = evt_strobe[EV_B_RISE];
      SRC_B_FALL:  evt_hit = evt_strobe[EV_B_FALL];
      default:     evt_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_divider.sv
module evt_divider #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_hit,
  input  logic             int_en,
  input  logic [CNT_W-1:0] div_sel,
  input  logic             flag_clr,
  output logic             irq_flag,
  output logic             irq_pulse
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             active;
  logic             reach;
  logic             fire;

  assign active  = int_en && (div_sel != '0);
  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign reach   = active && evt_hit && (cnt_inc >= {1'b0, div_sel});
  // a clear in the same cycle frees the slot for a new firing
  assign fire    = reach && (!irq_flag || flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      irq_flag  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      irq_flag  <= fire | (irq_flag & ~flag_clr);
      if (!active)
        cnt_q <= '0;
      else if (evt_hit) begin
        if (fire)
          cnt_q <= '0;
        else if (reach)
          cnt_q <= div_sel;          // saturate while pending
        else
          cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/evt_int_prescaler.sv
module evt_int_prescaler
  import evt_int_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               int_en,
  input  logic [CNT_W-1:0]   div_sel,
  input  logic               flag_clr,
  output logic               irq_flag,
  output logic               irq_pulse
);
  logic evt_hit;

  evt_src_mux u_mux (
    .evt_strobe (evt_strobe),
    .src_sel    (src_sel),
    .evt_hit    (evt_hit)
  );

  evt_divider #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .evt_hit   (evt_hit),
    .int_en    (int_en),
    .div_sel   (div_sel),
    .flag_clr  (flag_clr),
    .irq_flag  (irq_flag),
    .irq_pulse (irq_pulse)
  );
endmodule

// File: rtl/evt_int_prescaler_chk.sv
module evt_int_prescaler_chk (
  input logic clk,
  input logic rst,
  input logic int_en,
  input logic flag_clr,
  input logic irq_flag,
  input logic irq_pulse
);
  a_r8_pulse_with_flag: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> irq_flag);

  a_r8_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> irq_pulse);

  a_r6_no_pulse_pending: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !flag_clr |=> !irq_pulse);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !flag_clr |=> irq_flag);

  a_r4_disabled_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq_pulse);

  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !int_en |=> !irq_flag);

  a_r1_reset_clean: assert property (@(posedge clk)
    rst |=> !irq_flag && !irq_pulse);
endmodule

bind evt_int_prescaler evt_int_prescaler_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .int_en    (int_en),
  .flag_clr  (flag_clr),
  .irq_flag  (irq_flag),
  .irq_pulse (irq_pulse)
);

// File: tb/tb_evt_int_prescaler.sv
module tb_evt_int_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] evt_strobe = '0;
  logic [2:0] src_sel = '0;
  logic       int_en = 1'b0;
  logic [1:0] div_sel = '0;
  logic       flag_clr = 1'b0;
  logic       irq_flag;
  logic       irq_pulse;

  localparam logic [5:0] NONE = 6'b000000;
  localparam logic [5:0] ZERO = 6'b000001;
  localparam logic [5:0] PER  = 6'b000010;
  localparam logic [5:0] AUP  = 6'b000100;
  localparam logic [5:0] BUP  = 6'b010000;

  typedef struct {
    logic  flag;
    logic  pulse;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  evt_int_prescaler dut (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .src_sel(src_sel),
    .int_en(int_en), .div_sel(div_sel), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .irq_pulse(irq_pulse)
  );

  // driver: called at a negedge, drives one cycle, queues the expectation
  task automatic step(input logic [5:0] ev, input logic clr,
                      input logic ef, input logic ep, input string tag);
    exp_t e;
    evt_strobe = ev;
    flag_clr   = clr;
    e.flag = ef; e.pulse = ep; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: compares shortly after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (irq_flag !== e.flag || irq_pulse !== e.pulse) begin
          n_errors++;
          $display("FAIL %s: flag=%b pulse=%b expected flag=%b pulse=%b",
                   e.tag, irq_flag, irq_pulse, e.flag, e.pulse);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run hung, done=0 expected done=1");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(ZERO, 1'b0, 1'b0, 1'b0, "R1 reset");
    step(ZERO, 1'b1, 1'b0, 1'b0, "R1 reset");
    rst = 1'b0;
    src_sel = 3'd1; int_en = 1'b1; div_sel = 2'd3;
    // R3 every third
    step(ZERO, 1'b0, 1'b0, 1'b0, "R3 div3 ev1");
    step(NONE, 1'b0, 1'b0, 1'b0, "R3 idle");
    step(ZERO, 1'b0, 1'b0, 1'b0, "R3 div3 ev2");
    step(ZERO, 1'b0, 1'b1, 1'b1, "R3 div3 ev3 fires");
    step(NONE, 1'b0, 1'b1, 1'b0, "R8 one-cycle pulse");
    // R6 pending blocks, count saturates
    step(ZERO, 1'b0, 1'b1, 1'b0, "R6 pending ev");
    step(ZERO, 1'b0, 1'b1, 1'b0, "R6 pending ev");
    step(ZERO, 1'b0, 1'b1, 1'b0, "R6 pending ev saturate");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    step(NONE, 1'b0, 1'b0, 1'b0, "R5 stays clear");
    step(ZERO, 1'b0, 1'b1, 1'b1, "R6 first event after clear");
    // R7 clear and firing together
    step(ZERO, 1'b0, 1'b1, 1'b0, "R7 setup 1");
    step(ZERO, 1'b0, 1'b1, 1'b0, "R7 setup 2");
    step(ZERO, 1'b0, 1'b1, 1'b0, "R7 setup 3 saturate");
    step(ZERO, 1'b1, 1'b1, 1'b1, "R7 clear with fire");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    // R2 source selection, every event
    src_sel = 3'd2; div_sel = 2'd1;
    step(ZERO, 1'b0, 1'b0, 1'b0, "R2 zero ignored on period");
    step(PER,  1'b0, 1'b1, 1'b1, "R2 period counted");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    src_sel = 3'd3;
    step(ZERO, 1'b0, 1'b1, 1'b1, "R2 zero-or-period by zero");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    step(PER,  1'b0, 1'b1, 1'b1, "R2 zero-or-period by period");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    src_sel = 3'd6;
    step(AUP,  1'b0, 1'b0, 1'b0, "R2 A rise ignored on B rise");
    step(BUP,  1'b0, 1'b1, 1'b1, "R2 B rise counted");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    // R3 every second
    src_sel = 3'd1; div_sel = 2'd2;
    step(ZERO, 1'b0, 1'b0, 1'b0, "R3 div2 ev1");
    step(ZERO, 1'b0, 1'b1, 1'b1, "R3 div2 ev2 fires");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear");
    // R4 disabled by divide 0 and by enable
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 count before disable");
    div_sel = 2'd0;
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 div0");
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 div0");
    div_sel = 2'd3; int_en = 1'b0;
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 en0");
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 en0");
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 en0");
    int_en = 1'b1; div_sel = 2'd2;
    step(ZERO, 1'b0, 1'b0, 1'b0, "R4 count restarted at zero");
    step(ZERO, 1'b0, 1'b1, 1'b1, "R4 fires after restart");
    int_en = 1'b0;
    step(ZERO, 1'b0, 1'b1, 1'b0, "R4 pending flag kept when disabled");
    step(NONE, 1'b1, 1'b0, 1'b0, "R5 clear while disabled");
    step(NONE, 1'b0, 1'b0, 1'b0, "R5 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule